// File: doc/BRIEF.md
# Prescaled 8-bit PWM Generator

This block produces one pulse-width modulated output from a 256-step counter. The counter advances on a tick stream that is first chosen from two clock-enable strobes, a slow one and a fast one. It is then divided by a power of two that software selects. A small register port sets the compare value, the polarity, the division code and the tick source. Two write-one registers start and stop the channel, and a status bit confirms each change.

The output is in its active phase while the count is below the compare value. A period is therefore 256 prescaled ticks long, and the duty runs from 0/256 to 255/256. Compare, polarity and division settings are held in a shadow copy. The shadow copy reloads only when the counter wraps, and it also follows the programmed settings continuously while the channel is stopped. A running waveform therefore never changes shape in the middle of a period.

Top module: `pwm_prescaled_unit`

## Requirements
- R1: After reset the settings word reads 0, the tick source reads 0 (slow), the channel is stopped, status reads 0, and `pwm_out` is 1, which is the inactive level for polarity 0.
- R2: Register codes on `bus_addr` are as follows. Code 0 is the settings word, with compare in bits 15:8, polarity in bit 4 and division code in bits 2:0. Code 1 is the tick source, in bit 0. Code 2 is start, code 3 is stop and code 4 is status, in bit 0. Reads of codes 0, 1 and 4 return only those bits. All other bits read 0, and codes 2 and 3 read 0.
- R3: A write with bit 0 set to code 2 starts the channel, and a write with bit 0 set to code 3 stops it. Writes with bit 0 clear to either code change nothing.
- R4: The status bit changes one clock after the run state changes. It reads 0 in the first cycle after the start write and 1 in the next cycle.
- R5: The period is 256 × 2^N tick intervals and the active span is compare × 2^N tick intervals, where N is the division code.
- R6: A division code of 7 behaves as code 6.
- R7: Compare 0 gives no active phase. Compare 255 gives an active phase of 255 out of every 256 prescaled ticks.
- R8: Polarity 1 drives `pwm_out` high during the active phase. Polarity 0 drives it low during the active phase.
- R9: A tick-source bit of 0 advances the counter on `slow_tick`, and a value of 1 advances it on `fast_tick`.
- R10: Compare, polarity and division writes made while the channel runs take effect at the next counter wrap. The current period finishes with the old settings.
- R11: While stopped, the counter holds at 0 and `pwm_out` sits at the inactive level for the programmed polarity. After a start, counting begins from 0, and the active phase (when compare > 0) begins in the first cycle after the start write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | Slow timebase clock-enable strobe |
| fast_tick | input | 1 | Fast timebase clock-enable strobe |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Register code for both reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from `bus_addr` |
| pwm_out | output | 1 | Modulated output |

## Verification
Each error in internal state shows at `pwm_out` within one period. A counter that skips or stalls changes the measured spacing of rising edges. A divider that miscounts scales both the period and the active span. A shadow copy that reloads mid-period bends the pulse in the cycle after the offending write. Run and status faults show within two cycles of the start or stop write as a wrong status read or a non-idle output level. The bench therefore measures exact edge-to-edge intervals in cycles and compares sample-by-sample across a settings change.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;
   localparam int CMP_W   = 8;
   localparam int PS_W    = 3;
   localparam int CMP_LSB = 8;
   localparam int POL_BIT = 4;
   localparam int PS_LSB  = 0;

   typedef enum logic [2:0] {
      REG_CFG   = 3'd0,
      REG_TBASE = 3'd1,
      REG_EN    = 3'd2,
      REG_DIS   = 3'd3,
      REG_STAT  = 3'd4
   } reg_code_e;

   typedef struct packed {
      logic [CMP_W-1:0] cmp;
      logic             pol;
      logic [PS_W-1:0]  ps;
   } cfg_t;
endpackage

// File: rtl/pwm_cfg_regs.sv
`timescale 1ns/1ps
module pwm_cfg_regs
   import pwm_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output cfg_t              cfg_q,
   output logic              tb_sel_q,
   output logic              run_q,
   output logic              status_q
);
   localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(REG_CFG);
   localparam logic [ADDR_W-1:0] A_TBASE = ADDR_W'(REG_TBASE);
   localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(REG_EN);
   localparam logic [ADDR_W-1:0] A_DIS   = ADDR_W'(REG_DIS);
   localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(REG_STAT);

   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $error("pwm_cfg_regs: ADDR_W must be at least 3");
      end
      if (DATA_W < CMP_LSB + CMP_W) begin : g_bad_data
         $error("pwm_cfg_regs: DATA_W too narrow for the settings word");
      end
   endgenerate

   logic wr_cfg, wr_tb, wr_start, wr_stop;

   always_comb begin
      wr_cfg   = bus_we && (bus_addr == A_CFG);
      wr_tb    = bus_we && (bus_addr == A_TBASE);
      wr_start = bus_we && (bus_addr == A_EN)  && bus_wdata[0];
      wr_stop  = bus_we && (bus_addr == A_DIS) && bus_wdata[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q    <= '0;
         tb_sel_q <= 1'b0;
         run_q    <= 1'b0;
         status_q <= 1'b0;
      end else begin
         if (wr_cfg) begin
            cfg_q.cmp <= bus_wdata[CMP_LSB +: CMP_W];
            cfg_q.pol <= bus_wdata[POL_BIT];
            cfg_q.ps  <= bus_wdata[PS_LSB +: PS_W];
         end
         if (wr_tb) begin
            tb_sel_q <= bus_wdata[0];
         end
         if (wr_start) begin
            run_q <= 1'b1;
         end else if (wr_stop) begin
            run_q <= 1'b0;
         end
         status_q <= run_q;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_CFG) begin
         bus_rdata[CMP_LSB +: CMP_W] = cfg_q.cmp;
         bus_rdata[POL_BIT]          = cfg_q.pol;
         bus_rdata[PS_LSB +: PS_W]   = cfg_q.ps;
      end else if (bus_addr == A_TBASE) begin
         bus_rdata[0] = tb_sel_q;
      end else if (bus_addr == A_STAT) begin
         bus_rdata[0] = status_q;
      end
   end
endmodule

// File: rtl/pwm_tick_div.sv
`timescale 1ns/1ps
module pwm_tick_div
   import pwm_pkg::*;
#(
   parameter int MAX_SHIFT = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            tb_sel,
   input  logic            slow_tick,
   input  logic            fast_tick,
   input  logic [PS_W-1:0] shift,
   output logic            step
);
   localparam int DIV_W = MAX_SHIFT;

   generate
      if (MAX_SHIFT < 1 || MAX_SHIFT > (1 << PS_W) - 1) begin : g_bad_shift
         $error("pwm_tick_div: MAX_SHIFT out of range");
      end
   endgenerate

   logic             tick;
   logic [DIV_W-1:0] mask;
   logic [DIV_W-1:0] div_q;
   logic             last;

   assign tick = tb_sel ? fast_tick : slow_tick;

   generate
      for (genvar i = 0; i < DIV_W; i++) begin : g_mask
         assign mask[i] = (int'(shift) > i);
      end
   endgenerate

   assign last = (div_q == mask);
   assign step = run && tick && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
      end else if (!run) begin
         div_q <= '0;
      end else if (tick) begin
         div_q <= last ? '0 : div_q + 1'b1;
      end
   end
endmodule

// File: rtl/pwm_wave_core.sv
`timescale 1ns/1ps
module pwm_wave_core
   import pwm_pkg::*;
#(
   parameter int MAX_SHIFT = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             step,
   input  cfg_t             cfg,
   output cfg_t             shadow_q,
   output logic [CMP_W-1:0] cnt_q,
   output logic             pwm_out
);
   localparam logic [CMP_W-1:0] CNT_TOP = {CMP_W{1'b1}};
   localparam logic [PS_W-1:0]  PS_CAP  = PS_W'(MAX_SHIFT);

   cfg_t cfg_eff;
   logic active;

   always_comb begin
      cfg_eff = cfg;
      if (cfg.ps > PS_CAP) begin
         cfg_eff.ps = PS_CAP;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         shadow_q <= '0;
      end else if (!run) begin
         cnt_q    <= '0;
         shadow_q <= cfg_eff;
      end else if (step) begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == CNT_TOP) begin
            shadow_q <= cfg_eff;
         end
      end
   end

   assign active  = (cnt_q < shadow_q.cmp);
   assign pwm_out = run ? (shadow_q.pol ? active : !active) : !shadow_q.pol;
endmodule

// File: rtl/pwm_prescaled_unit.sv
`timescale 1ns/1ps
module pwm_prescaled_unit
   import pwm_pkg::*;
#(
   parameter int ADDR_W    = 3,
   parameter int DATA_W    = 32,
   parameter int MAX_SHIFT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_tick,
   input  logic              fast_tick,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              pwm_out
);
   cfg_t             cfg_q;
   cfg_t             shadow_q;
   logic             tb_sel_q;
   logic             run_q;
   logic             status_q;
   logic             step;
   logic [CMP_W-1:0] cnt_q;

   pwm_cfg_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .cfg_q     (cfg_q),
      .tb_sel_q  (tb_sel_q),
      .run_q     (run_q),
      .status_q  (status_q)
   );

   pwm_tick_div #(
      .MAX_SHIFT (MAX_SHIFT)
   ) i_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run_q),
      .tb_sel    (tb_sel_q),
      .slow_tick (slow_tick),
      .fast_tick (fast_tick),
      .shift     (shadow_q.ps),
      .step      (step)
   );

   pwm_wave_core #(
      .MAX_SHIFT (MAX_SHIFT)
   ) i_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_q),
      .step     (step),
      .cfg      (cfg_q),
      .shadow_q (shadow_q),
      .cnt_q    (cnt_q),
      .pwm_out  (pwm_out)
   );
endmodule

// File: rtl/pwm_prescaled_chk.sv
`timescale 1ns/1ps
module pwm_prescaled_chk
   import pwm_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              pwm_out,
   input logic              run_q,
   input logic              status_q,
   input logic              step,
   input logic [CMP_W-1:0]  cnt_q,
   input logic [CMP_W-1:0]  cmp_a,
   input logic              pol_a
);
   p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(REG_EN) && bus_wdata[0]) |=> run_q);

   p_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(REG_DIS) && bus_wdata[0]) |=> !run_q);

   p_status_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_q) |-> !status_q ##1 status_q);

   p_status_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_q) |-> status_q ##1 !status_q);

   p_cnt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !step) |=> $stable(cnt_q));

   p_cnt_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && step) |=> (cnt_q == CMP_W'($past(cnt_q) + 1)));

   p_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && cnt_q == {CMP_W{1'b1}}) |-> (pwm_out == !pol_a));

   p_shadow_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && $past(run_q) && cnt_q != '0) |-> ($stable(cmp_a) && $stable(pol_a)));

   p_idle_cnt_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && $past(!run_q)) |-> (cnt_q == '0));
endmodule

bind pwm_prescaled_unit pwm_prescaled_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .pwm_out   (pwm_out),
   .run_q     (run_q),
   .status_q  (status_q),
   .step      (step),
   .cnt_q     (cnt_q),
   .cmp_a     (shadow_q.cmp),
   .pol_a     (shadow_q.pol)
);

// File: tb/test_pwm_prescaled_unit.sv
`timescale 1ns/1ps
module test_pwm_prescaled_unit;
   localparam int ADDR_W   = 3;
   localparam int DATA_W   = 32;
   localparam int SLOW_DIV = 3;
   localparam int LIMIT    = 40000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              slow_tick = 1'b0;
   logic              fast_tick = 1'b1;
   logic              bus_we = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;
   logic              pwm_out;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   pwm_prescaled_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_pwm_prescaled_unit (
      .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .pwm_out(pwm_out)
   );

   always #2 clk = ~clk;

   initial begin
      int cyc;
      cyc = 0;
      forever begin
         @(negedge clk);
         cyc++;
         slow_tick = (cyc % SLOW_DIV == 0);
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input int code, input logic [DATA_W-1:0] data);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = ADDR_W'(code); bus_wdata = data;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic bus_rd(input int code, output logic [DATA_W-1:0] data);
      @(negedge clk);
      bus_addr = ADDR_W'(code);
      #1 data = bus_rdata;
   endtask

   function automatic logic [DATA_W-1:0] cfg_word(input int cmp, input int pol, input int ps);
      return DATA_W'((cmp << 8) | (pol << 4) | ps);
   endfunction

   task automatic measure(input logic lvl, input int exp_per, input int exp_hi, input string tag);
      int n, r1, f1, r2;
      logic prev, cur;
      n = 0; r1 = -1; f1 = -1; r2 = -1;
      #1 prev = (pwm_out == lvl);
      while (n < LIMIT && r2 < 0) begin
         @(negedge clk);
         #1 cur = (pwm_out == lvl);
         n++;
         if (cur && !prev) begin
            if (r1 < 0) r1 = n; else r2 = n;
         end
         if (!cur && prev && r1 >= 0 && f1 < 0) f1 = n;
         prev = cur;
      end
      check(r2 - r1 == exp_per, {tag, " period"}, r2 - r1, exp_per);
      check(f1 - r1 == exp_hi, {tag, " active span"}, f1 - r1, exp_hi);
   endtask

   task automatic stop_and_cfg(input int cmp, input int pol, input int ps, input int sel);
      bus_wr(3, 32'h1);
      bus_wr(0, cfg_word(cmp, pol, ps));
      bus_wr(1, DATA_W'(sel));
   endtask

   task automatic t_reset();
      logic [DATA_W-1:0] d;
      #1 check(pwm_out === 1'b1, "R1 idle output", int'(pwm_out), 1);
      bus_rd(0, d); check(d == 0, "R1 settings", int'(d), 0);
      bus_rd(1, d); check(d == 0, "R1 tick source", int'(d), 0);
      bus_rd(4, d); check(d == 0, "R1 status", int'(d), 0);
   endtask

   task automatic t_regmap();
      logic [DATA_W-1:0] d;
      bus_wr(0, 32'hFFFF_FFFF);
      bus_rd(0, d); check(d == 32'h0000_FF17, "R2 settings readback", int'(d), 32'hFF17);
      bus_wr(1, 32'hFFFF_FFFE);
      bus_rd(1, d); check(d == 0, "R2 source bit0 only", int'(d), 0);
      bus_rd(2, d); check(d == 0, "R2 start reads 0", int'(d), 0);
      bus_rd(3, d); check(d == 0, "R2 stop reads 0", int'(d), 0);
      bus_wr(0, 32'h0);
   endtask

   task automatic t_zero_writes_idle();
      logic [DATA_W-1:0] d;
      bus_wr(0, cfg_word(100, 1, 0));
      bus_wr(2, 32'hFFFF_FFFE);
      @(negedge clk);
      bus_rd(4, d); check(d == 0, "R3 zero start ignored", int'(d), 0);
      #0 check(pwm_out == 1'b0, "R3 output stays idle", int'(pwm_out), 0);
   endtask

   task automatic t_start_status();
      logic s0, s1, o0;
      stop_and_cfg(64, 1, 0, 1);
      bus_wr(2, 32'h1);
      bus_addr = ADDR_W'(4);
      #1 s0 = bus_rdata[0]; o0 = pwm_out;
      @(negedge clk);
      #1 s1 = bus_rdata[0];
      check(s0 == 1'b0, "R4 status lags start", int'(s0), 0);
      check(s1 == 1'b1, "R4 status after one cycle", int'(s1), 1);
      check(o0 == 1'b1, "R11 active from first cycle", int'(o0), 1);
      measure(1'b1, 256, 64, "R5 code0");
   endtask

   task automatic t_prescale();
      bus_wr(0, cfg_word(64, 1, 2));
      measure(1'b1, 1024, 256, "R5 code2");
      bus_wr(0, cfg_word(3, 1, 7));
      measure(1'b1, 16384, 192, "R6 code7 as code6");
   endtask

   task automatic t_duty_edges();
      int highs;
      bus_wr(0, cfg_word(255, 1, 0));
      measure(1'b1, 256, 255, "R7 compare 255");
      stop_and_cfg(0, 1, 0, 1);
      bus_wr(2, 32'h1);
      highs = 0;
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         #1 if (pwm_out) highs++;
      end
      check(highs == 0, "R7 compare 0 never active", highs, 0);
   endtask

   task automatic t_polarity();
      logic d;
      stop_and_cfg(64, 0, 0, 1);
      @(negedge clk);
      #1 d = pwm_out;
      check(d == 1'b1, "R11 idle level polarity 0", int'(d), 1);
      bus_wr(2, 32'h1);
      measure(1'b0, 256, 64, "R8 polarity 0");
   endtask

   task automatic t_source();
      stop_and_cfg(10, 1, 1, 0);
      bus_wr(2, 32'h1);
      measure(1'b1, 256 * 2 * SLOW_DIV, 10 * 2 * SLOW_DIV, "R9 slow source");
      bus_wr(1, 32'h1);
      measure(1'b1, 512, 20, "R9 fast source");
   endtask

   task automatic t_deferred();
      int errs_a, errs_b;
      logic exp;
      stop_and_cfg(64, 1, 0, 1);
      bus_wr(2, 32'h1);
      errs_a = 0; errs_b = 0;
      for (int i = 0; i < 512; i++) begin
         if (i > 0) @(negedge clk);
         if (i == 130) begin
            bus_we = 1'b1; bus_addr = ADDR_W'(0); bus_wdata = cfg_word(200, 1, 0);
         end
         if (i == 131) begin
            bus_we = 1'b0; bus_wdata = '0;
         end
         exp = (i < 256) ? (i < 64) : ((i - 256) < 200);
         #1 if (pwm_out !== exp) begin
            if (i < 256) errs_a++; else errs_b++;
         end
      end
      check(errs_a == 0, "R10 old settings until wrap", errs_a, 0);
      check(errs_b == 0, "R10 new settings after wrap", errs_b, 0);
   endtask

   task automatic t_stop();
      logic [DATA_W-1:0] d;
      int errs;
      bus_wr(3, 32'h0);
      @(negedge clk);
      bus_rd(4, d); check(d == 1, "R3 zero stop ignored", int'(d), 1);
      measure(1'b1, 256, 200, "R3 still running");
      bus_wr(3, 32'h1);
      bus_addr = ADDR_W'(4);
      #1 check(bus_rdata[0] == 1'b1, "R4 status lags stop", int'(bus_rdata[0]), 1);
      errs = 0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         #1 if (pwm_out !== 1'b0) errs++;
      end
      check(bus_rdata[0] == 1'b0, "R4 status after stop", int'(bus_rdata[0]), 0);
      check(errs == 0, "R11 held idle while stopped", errs, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regmap();
      t_zero_writes_idle();
      t_start_status();
      t_prescale();
      t_duty_edges();
      t_polarity();
      t_source();
      t_deferred();
      t_stop();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule